// File: doc/BRIEF.md
# I2C Conversion Command and Readout Target

This block is a bus target on a two-wire serial bus. It sits in front of an analog-to-digital converter. A bus master first writes a one-byte command that selects the input channel, a power-down option and the result resolution. Those settings are held on the block's outputs, where the converter reads them. The master can then read conversion results as often as it likes. Each read transaction raises a one-cycle conversion request toward the converter and accepts the result on a strobe. The result is then shifted out most significant bit first, as one byte in 8-bit mode or as two left-justified bytes in 12-bit mode.

SCL and SDA are sampled through synchronisers on the system clock. The block only ever pulls SDA low, through an open-drain enable. A single state machine handles the transaction:

- `ST_IDLE`: waits for a START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: acknowledges a matching address.
- `ST_CMD` and `ST_CMD_ACK`: receive and acknowledge command bytes.
- `ST_TX`: shifts a result byte out.
- `ST_MACK`: samples the master's acknowledge.
- `ST_IGNORE`: waits out a transaction that is not for this target, or that is already finished.

The transitions are as follows:

- Any state goes to `ST_ADDR` on START, including a repeated START.
- Any state goes to `ST_IDLE` on STOP.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match, or to `ST_IGNORE` on a mismatch.
- `ST_ADDR_ACK` goes to `ST_CMD` for a write, or to `ST_TX` for a read.
- `ST_CMD` goes to `ST_CMD_ACK`, and `ST_CMD_ACK` goes back to `ST_CMD`.
- `ST_TX` goes to `ST_MACK`.
- `ST_MACK` goes back to `ST_TX` when a second byte is due, or to `ST_IGNORE` otherwise.

Top module: `i2c_adc_target`

## Requirements
- R1: After reset `sda_oe` and `conv_req` are 0, and the settings outputs are channel 0, power-down 0 and 12-bit mode (`cfg_mode8`=0).
- R2: The target acknowledges an address byte whose upper seven bits equal `DEV_ADDR`. For any other address it gives no acknowledge and pulls SDA low for no bit until the next START, and a byte written after the mismatch leaves the settings unchanged.
- R3: A command byte is sent MSB first. It is latched only when bit 7 is 1. Bits 6..4 give the channel, bit 2 the power-down flag, and bit 1 the mode (1 = 8-bit, 0 = 12-bit). Bits 3 and 0 have no effect.
- R4: A command byte whose bit 7 is 0 is still acknowledged but leaves the settings unchanged.
- R5: Several command bytes in one write transaction are each acknowledged, and the last valid one sets the outputs.
- R6: Each address byte that matches with R/W=1 raises `conv_req` for exactly one clock cycle before the first data bit is driven. The result captured on `conv_done` is the one sent.
- R7: In 12-bit mode the first byte is result bits 11..4. After a master ACK, the second byte is result bits 3..0 followed by four zeros.
- R8: In 8-bit mode one byte, result bits 11..4, is sent.
- R9: After the last defined byte, or on a master NACK, the target releases SDA. Further bits the master clocks read as 1.
- R10: A command ended by a repeated START instead of a STOP takes effect for the read that follows.
- R11: `sda_oe` changes only while SCL is low.
- R12: Back-to-back reads that use no new command each start their own conversion and return that conversion's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| conv_req | output | 1 | One-cycle conversion request |
| conv_done | input | 1 | Result valid strobe |
| conv_data | input | RES_W | Conversion result |
| cfg_chan | output | 3 | Selected input channel |
| cfg_pd | output | 1 | Power-down control flag |
| cfg_mode8 | output | 1 | 1 = 8-bit mode, 0 = 12-bit mode |

## Verification
The bound checker checks four properties on every cycle:

- SDA drive changes only while SCL is low.
- Conversion requests are single-cycle pulses, issued only while SCL is low.
- Settings update only during the target's own acknowledge of a command.

The bench's directed scenarios are the only way to show the byte-level behaviour. This covers:

- the command field positions and don't-care bits;
- the rejection of commands without a start bit;
- address mismatch handling;
- the left-justified two-byte layout;
- SDA being released after NACK or after the last byte;
- a fresh conversion on every read.

// File: rtl/i2c_adc_pkg.sv
package i2c_adc_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } tgt_state_t;

    typedef struct packed {
        logic [2:0] chan;
        logic       pd;
        logic       mode8;
    } adc_cfg_t;

    localparam adc_cfg_t CFG_RESET = '{chan: 3'd0, pd: 1'b0, mode8: 1'b0};

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_p;
    logic                   sda_p;
    logic                   scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_p  <= scl_ff[LAST];
            sda_p  <= sda_ff[LAST];
        end
    end

    assign scl_s     = scl_ff[LAST];
    assign sda_s     = sda_ff[LAST];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    // data edges while the clock line stays high mark frame boundaries
    assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
    assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_adc_cmd_reg.sv
module i2c_adc_cmd_reg
    import i2c_adc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [7:0]  cmd_byte,
    output adc_cfg_t    cfg
);

    adc_cfg_t decoded;
    logic     cmd_valid;
    logic     unused_dc;

    always_comb begin
        cmd_valid     = cmd_byte[7];
        decoded.chan  = cmd_byte[6:4];
        decoded.pd    = cmd_byte[2];
        decoded.mode8 = cmd_byte[1];
    end

    assign unused_dc = cmd_byte[3] ^ cmd_byte[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else if (load && cmd_valid) begin
            cfg <= decoded;
        end
    end

endmodule

// File: rtl/i2c_adc_result_buf.sv
module i2c_adc_result_buf #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic [7:0]       byte_hi,
    output logic [7:0]       byte_lo
);

    localparam int LO_BITS  = RES_W - 8;
    localparam int PAD_BITS = 8 - LO_BITS;

    logic [RES_W-1:0] res_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (conv_done) begin
            res_q <= conv_data;
        end
    end

    assign byte_hi = res_q[RES_W-1 -: 8];
    assign byte_lo = {res_q[LO_BITS-1:0], {PAD_BITS{1'b0}}};

endmodule

// File: rtl/i2c_adc_fsm.sv
module i2c_adc_fsm
    import i2c_adc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       mode8,
    input  logic [7:0] byte_hi,
    input  logic [7:0] byte_lo,
    output logic [7:0] rx_byte,
    output logic       cmd_load,
    output logic       conv_req,
    output logic       sda_oe
);

    tgt_state_t        state_q;
    tgt_state_t        state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [7:0]        rx_sh;
    logic [7:0]        tx_sh;
    logic              rd_q;
    logic              more_q;
    logic              byte_idx;
    logic              byte_done;
    logic              addr_hit;

    assign byte_done = (bit_cnt == CNT_W'(BYTE_W));
    assign addr_hit  = (rx_sh[7:1] == DEV_ADDR);
    assign rx_byte   = rx_sh;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (bus_stop) begin
            state_d = ST_IDLE;
        end else if (bus_start) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_ADDR:     if (scl_fall && byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_d = rd_q ? ST_TX : ST_CMD;
                ST_CMD:      if (scl_fall && byte_done) state_d = ST_CMD_ACK;
                ST_CMD_ACK:  if (scl_fall) state_d = ST_CMD;
                ST_TX:       if (scl_fall && byte_done) state_d = ST_MACK;
                ST_MACK:     if (scl_fall) state_d = more_q ? ST_TX : ST_IGNORE;
                default:     state_d = state_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rd_q     <= 1'b0;
            more_q   <= 1'b0;
            byte_idx <= 1'b0;
            cmd_load <= 1'b0;
            conv_req <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            cmd_load <= 1'b0;
            conv_req <= 1'b0;
            if (bus_start || bus_stop) begin
                bit_cnt  <= '0;
                sda_oe   <= 1'b0;
                byte_idx <= 1'b0;
                more_q   <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && byte_done) begin
                            bit_cnt <= '0;
                            if (addr_hit) begin
                                sda_oe   <= 1'b1;
                                rd_q     <= rx_sh[0];
                                conv_req <= rx_sh[0];
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt  <= '0;
                            byte_idx <= 1'b0;
                            if (rd_q) begin
                                tx_sh  <= byte_hi;
                                sda_oe <= ~byte_hi[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_CMD: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && byte_done) begin
                            bit_cnt  <= '0;
                            sda_oe   <= 1'b1;
                            cmd_load <= 1'b1;
                        end
                    end
                    ST_CMD_ACK: begin
                        if (scl_fall) sda_oe <= 1'b0;
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (byte_done) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                            end else if (bit_cnt != '0) begin
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                sda_oe <= ~tx_sh[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            more_q <= ~sda_s & ~mode8 & ~byte_idx;
                        end else if (scl_fall && more_q) begin
                            tx_sh    <= byte_lo;
                            sda_oe   <= ~byte_lo[7];
                            byte_idx <= 1'b1;
                            bit_cnt  <= '0;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_adc_target.sv
module i2c_adc_target
    import i2c_adc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         RES_W       = 12,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic             conv_req,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic [2:0]       cfg_chan,
    output logic             cfg_pd,
    output logic             cfg_mode8
);

    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       bus_start;
    logic       bus_stop;
    logic [7:0] rx_byte;
    logic       cmd_load;
    logic [7:0] byte_hi;
    logic [7:0] byte_lo;
    adc_cfg_t   cfg;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_adc_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .mode8     (cfg.mode8),
        .byte_hi   (byte_hi),
        .byte_lo   (byte_lo),
        .rx_byte   (rx_byte),
        .cmd_load  (cmd_load),
        .conv_req  (conv_req),
        .sda_oe    (sda_oe)
    );

    i2c_adc_cmd_reg u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_load),
        .cmd_byte (rx_byte),
        .cfg      (cfg)
    );

    i2c_adc_result_buf #(.RES_W(RES_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .byte_hi   (byte_hi),
        .byte_lo   (byte_lo)
    );

    assign cfg_chan  = cfg.chan;
    assign cfg_pd    = cfg.pd;
    assign cfg_mode8 = cfg.mode8;

endmodule

// File: rtl/i2c_adc_target_chk.sv
module i2c_adc_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       conv_req,
    input logic [2:0] cfg_chan,
    input logic       cfg_pd,
    input logic       cfg_mode8
);

    // R11
    oe_edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R6
    conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R6
    conv_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> !scl_i);

    // R3
    cfg_during_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cfg_chan, cfg_pd, cfg_mode8}) |-> (sda_oe && !scl_i));

endmodule

bind i2c_adc_target i2c_adc_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .conv_req  (conv_req),
    .cfg_chan  (cfg_chan),
    .cfg_pd    (cfg_pd),
    .cfg_mode8 (cfg_mode8)
);

// File: tb/tb_i2c_adc_target.sv
module tb_i2c_adc_target;

    localparam int         Q    = 10;
    localparam int         HP   = 20;
    localparam logic [6:0] ADDR = 7'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        conv_req;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic [2:0]  cfg_chan;
    logic        cfg_pd;
    logic        cfg_mode8;
    logic        sda_line;

    int          n_chk = 0;
    int          n_err = 0;
    int          conv_cnt = 0;
    int          mon_viol = 0;
    logic [11:0] stub_val = 12'h000;
    logic [2:0]  stub_dly = '0;
    logic        prev_oe = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_adc_target dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .conv_req  (conv_req),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .cfg_chan  (cfg_chan),
        .cfg_pd    (cfg_pd),
        .cfg_mode8 (cfg_mode8)
    );

    // converter stub: answers three cycles after a request
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_req) begin
            conv_cnt <= conv_cnt + 1;
            stub_dly <= 3'd3;
        end else if (stub_dly != 0) begin
            stub_dly <= stub_dly - 1'b1;
            if (stub_dly == 3'd1) begin
                conv_done <= 1'b1;
                conv_data <= stub_val;
            end
        end
    end

    // R11 monitor: drive edges only while SCL low
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl) mon_viol++;
        prev_oe <= sda_oe;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; scl = 1'b1; wt(HP);
        sda_m = 1'b0; wt(HP);
        scl = 1'b0;
    endtask

    task automatic i2c_rstart();
        wt(Q); sda_m = 1'b1; wt(Q);
        scl = 1'b1; wt(HP);
        sda_m = 1'b0; wt(HP);
        scl = 1'b0;
    endtask

    task automatic i2c_stop();
        wt(Q); sda_m = 1'b0; wt(Q);
        scl = 1'b1; wt(HP);
        sda_m = 1'b1; wt(HP);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            wt(Q); sda_m = b[i]; wt(Q);
            scl = 1'b1; wt(HP);
            scl = 1'b0;
        end
        wt(Q); sda_m = 1'b1; wt(Q);
        scl = 1'b1; wt(Q);
        ack = ~sda_line;
        wt(Q);
        scl = 1'b0;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wt(Q); sda_m = 1'b1; wt(Q);
            scl = 1'b1; wt(Q);
            b[i] = sda_line;
            wt(Q);
            scl = 1'b0;
        end
        wt(Q); sda_m = ~give_ack; wt(Q);
        scl = 1'b1; wt(HP);
        scl = 1'b0;
    endtask

    task automatic write_cmd(input logic [7:0] c, input string req);
        logic a;
        i2c_start();
        write_byte({ADDR, 1'b0}, a);
        check(a, req, a, 1);
        write_byte(c, a);
        check(a, req, a, 1);
        i2c_stop();
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0 && conv_req == 1'b0, "R1", {sda_oe, conv_req}, 0);
        check({cfg_chan, cfg_pd, cfg_mode8} == 5'b0, "R1", {cfg_chan, cfg_pd, cfg_mode8}, 0);
    endtask

    task automatic t_command();
        logic a;
        // R3: 1_101_0_1_0_0 -> chan 5, pd 1, 12-bit
        write_cmd(8'hD4, "R3");
        check({cfg_chan, cfg_pd, cfg_mode8} == {3'd5, 1'b1, 1'b0}, "R3", {cfg_chan, cfg_pd, cfg_mode8}, {3'd5, 2'b10});
        // R3: the same with bits 3 and 0 set
        write_cmd(8'h08, "R3");
        write_cmd(8'hDD, "R3");
        check({cfg_chan, cfg_pd, cfg_mode8} == {3'd5, 1'b1, 1'b0}, "R3", {cfg_chan, cfg_pd, cfg_mode8}, {3'd5, 2'b10});
        // R4: bit 7 clear -> acked, not latched
        write_cmd(8'h7A, "R4");
        check({cfg_chan, cfg_pd, cfg_mode8} == {3'd5, 1'b1, 1'b0}, "R4", {cfg_chan, cfg_pd, cfg_mode8}, {3'd5, 2'b10});
        // R5: two bytes in one write, last wins
        i2c_start();
        write_byte({ADDR, 1'b0}, a); check(a, "R5", a, 1);
        write_byte(8'hB0, a);        check(a, "R5", a, 1);
        write_byte(8'hE6, a);        check(a, "R5", a, 1);
        i2c_stop();
        check({cfg_chan, cfg_pd, cfg_mode8} == {3'd6, 1'b1, 1'b1}, "R5", {cfg_chan, cfg_pd, cfg_mode8}, {3'd6, 2'b11});
    endtask

    task automatic t_wrong_addr();
        logic a;
        i2c_start();
        write_byte({7'h21, 1'b0}, a);
        check(!a, "R2", a, 0);
        write_byte(8'h9E, a);
        check(!a, "R2", a, 0);
        i2c_stop();
        check({cfg_chan, cfg_pd, cfg_mode8} == {3'd6, 1'b1, 1'b1}, "R2", {cfg_chan, cfg_pd, cfg_mode8}, {3'd6, 2'b11});
    endtask

    task automatic t_read12();
        logic a;
        logic [7:0] b;
        int c0;
        write_cmd(8'hA0, "R7");
        c0 = conv_cnt;
        stub_val = 12'hABC;
        i2c_start();
        write_byte({ADDR, 1'b1}, a);
        check(a, "R6", a, 1);
        read_byte(1'b1, b);
        check(b == 8'hAB, "R7", b, 8'hAB);
        read_byte(1'b0, b);
        check(b == 8'hC0, "R7", b, 8'hC0);
        i2c_stop();
        check(conv_cnt == c0 + 1, "R6", conv_cnt - c0, 1);
        check(sda_oe == 1'b0, "R9", sda_oe, 0);
    endtask

    task automatic t_read8_rstart();
        logic a;
        logic [7:0] b;
        // R10: command 1_001_0_0_1_0 ended by repeated START
        i2c_start();
        write_byte({ADDR, 1'b0}, a);
        write_byte(8'h92, a);
        check(a, "R10", a, 1);
        stub_val = 12'h5E7;
        i2c_rstart();
        write_byte({ADDR, 1'b1}, a);
        check(a, "R10", a, 1);
        check(cfg_chan == 3'd1 && cfg_mode8, "R10", {cfg_chan, cfg_mode8}, {3'd1, 1'b1});
        read_byte(1'b0, b);
        check(b == 8'h5E, "R8", b, 8'h5E);
        wt(Q);
        check(sda_oe == 1'b0, "R9", sda_oe, 0);
        i2c_stop();
    endtask

    task automatic t_back_to_back();
        logic a;
        logic [7:0] b;
        int c0;
        c0 = conv_cnt;
        stub_val = 12'h123;
        i2c_start();
        write_byte({ADDR, 1'b1}, a);
        read_byte(1'b0, b);
        check(b == 8'h12, "R12", b, 8'h12);
        stub_val = 12'h456;
        i2c_rstart();
        write_byte({ADDR, 1'b1}, a);
        read_byte(1'b0, b);
        check(b == 8'h45, "R12", b, 8'h45);
        i2c_stop();
        check(conv_cnt == c0 + 2, "R12", conv_cnt - c0, 2);
    endtask

    task automatic t_ack_past_end();
        logic a;
        logic [7:0] b;
        write_cmd(8'h80, "R9");
        stub_val = 12'h3F1;
        i2c_start();
        write_byte({ADDR, 1'b1}, a);
        read_byte(1'b1, b);
        check(b == 8'h3F, "R7", b, 8'h3F);
        read_byte(1'b1, b);
        check(b == 8'h10, "R7", b, 8'h10);
        read_byte(1'b0, b);
        check(b == 8'hFF, "R9", b, 8'hFF);
        i2c_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_command();
        t_wrong_addr();
        t_read12();
        t_read8_rstart();
        t_back_to_back();
        t_ack_past_end();
        check(mon_viol == 0, "R11", mon_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule